// File: doc/BRIEF.md
# Bit-Addressable PHY Tuning Receiver

This block sits on the PHY side of a bit-serial configuration path. Software fills a shared control word with a bit address and a data bit. It then pulses the strobe bit that belongs to one port. The receiver owned by that port synchronizes the word. On each rising edge of its own strobe, it writes the data bit into a 256-bit configuration image at the addressed position.

Multi-bit tuning values are rebuilt from separate single-bit writes. The receiver decodes three fields from the image continuously:

- a calibration enable bit;
- a 5-bit transmit amplitude;
- a 2-bit disconnect threshold.

The port number is a parameter. The strobe for port `n` is control-word bit `2*n`. The reset value of the amplitude field is also a parameter.

Top module: `cfg_bit_rx`

## Requirements
- R1: After reset, `cal_en` is 0, `disc_th` is 0 and `tx_amp` equals the parameter `AMP_RST`. Every other bit of the image is also 0.
- R2: A rising edge of the port strobe writes control-word bit 7 (the data bit) into the image at the bit address held in control-word bits 15:8.
- R3: Only control-word bit `2*PORT_IDX` acts as the strobe. Rising edges on the strobe bits of other ports (any other even bit below 8) change no output.
- R4: A capture happens only on a 0-to-1 transition of the synchronized strobe. Changing the address or data fields while the strobe stays low, or while it stays high, changes no output.
- R5: `cal_en` reflects image bit address 0x0c.
- R6: `tx_amp` bit k reflects image bit address 0x20+k, for k = 0..4, so the LSB is at 0x20.
- R7: `disc_th` bit k reflects image bit address 0x2a+k, for k = 0..1, so the LSB is at 0x2a.
- R8: A captured value reaches the outputs at the third rising clock edge after the strobe input goes high. The first two edges pass through the two synchronizer stages; the third edge writes the image.
- R9: Writes to image addresses outside the three tuning fields leave all outputs unchanged.
- R10: Writing a 0 to a bit that holds 1 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | CTL_W | Shared control word: bits 15:8 hold the address, bit 7 the data, even bits below 8 the port strobes |
| cal_en | output | 1 | Calibration enable (image bit 0x0c) |
| tx_amp | output | 5 | Transmit amplitude (image bits 0x20..0x24) |
| disc_th | output | 2 | Disconnect threshold (image bits 0x2a..0x2b) |

## Verification
The assertions assume the address and data fields settle at least one clock before the strobe rises and stay put until it has fallen again. Because all three fields pass through the same two-flop stage, they are only seen together when held this way. The stimulus therefore changes the fields only with the strobe low and waits two clocks before raising it. Wherever the bench moves the fields while the strobe is high, it is deliberately testing R4. The strobe is always held high for several clocks, so every rise is seen by the synchronizer.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int ADDR_W    = 8;
  localparam int SPACE     = 1 << ADDR_W;
  localparam int ADDR_LSB  = 8;
  localparam int DATA_POS  = 7;
  localparam int CAL_ADDR  = 12;
  localparam int AMP_BASE  = 32;
  localparam int AMP_W     = 5;
  localparam int DISC_BASE = 42;
  localparam int DISC_W    = 2;

  typedef logic [ADDR_W-1:0] bit_addr_t;

  typedef struct packed {
    bit_addr_t addr;
    logic      data;
    logic      strobe;
  } ctl_fields_t;

  localparam int FIELDS_W = $bits(ctl_fields_t);

  function automatic int strobe_pos(input int idx);
    return 2 * idx;
  endfunction

  function automatic logic [SPACE-1:0] reset_image(input logic [AMP_W-1:0] amp);
    logic [SPACE-1:0] img;
    img = '0;
    for (int k = 0; k < AMP_W; k++) img[AMP_BASE+k] = amp[k];
    return img;
  endfunction

  function automatic logic in_tuning(input bit_addr_t a);
    return (int'(a) == CAL_ADDR) ||
           (int'(a) >= AMP_BASE && int'(a) < AMP_BASE + AMP_W) ||
           (int'(a) >= DISC_BASE && int'(a) < DISC_BASE + DISC_W);
  endfunction
endpackage

// File: rtl/cfg_field_sync.sv
module cfg_field_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int              ADDR_W  = 8,
  parameter int              SPACE   = 256,
  parameter logic [SPACE-1:0] RST_IMG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d,
  output logic [SPACE-1:0]  img
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  img       <= RST_IMG;
    else if (we) img[addr] <= d;
  end
endmodule

// File: rtl/cfg_bit_rx.sv
module cfg_bit_rx
  import cfgrx_pkg::*;
#(
  parameter int               CTL_W    = 32,
  parameter int               PORT_IDX = 0,
  parameter logic [AMP_W-1:0] AMP_RST  = 5'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_word,
  output logic              cal_en,
  output logic [AMP_W-1:0]  tx_amp,
  output logic [DISC_W-1:0] disc_th
);
  localparam int               STB_POS = strobe_pos(PORT_IDX);
  localparam logic [SPACE-1:0] RST_IMG = reset_image(AMP_RST);

  ctl_fields_t      raw_f, sync_f;
  logic             rise_evt;
  bit_addr_t        wr_addr;
  logic             wr_bit;
  logic [SPACE-1:0] image;

  assign raw_f.addr   = ctl_word[ADDR_LSB +: ADDR_W];
  assign raw_f.data   = ctl_word[DATA_POS];
  assign raw_f.strobe = ctl_word[STB_POS];

  cfg_field_sync #(.W(FIELDS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_f), .q(sync_f)
  );

  cfg_rise_det u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(sync_f.strobe), .rise(rise_evt)
  );

  assign wr_addr = sync_f.addr;
  assign wr_bit  = sync_f.data;

  cfg_bit_store #(.ADDR_W(ADDR_W), .SPACE(SPACE), .RST_IMG(RST_IMG)) u_store (
    .clk(clk), .rst_n(rst_n), .we(rise_evt), .addr(wr_addr), .d(wr_bit), .img(image)
  );

  assign cal_en = image[CAL_ADDR];

  for (genvar k = 0; k < AMP_W; k++) begin : g_amp
    assign tx_amp[k] = image[AMP_BASE+k];
  end

  for (genvar k = 0; k < DISC_W; k++) begin : g_disc
    assign disc_th[k] = image[DISC_BASE+k];
  end
endmodule

// File: rtl/cfg_bit_rx_chk.sv
module cfg_bit_rx_chk
  import cfgrx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rise_evt,
  input bit_addr_t         wr_addr,
  input logic              wr_bit,
  input logic              cal_en,
  input logic [AMP_W-1:0]  tx_amp,
  input logic [DISC_W-1:0] disc_th
);
  logic hit_tune;
  assign hit_tune = in_tuning(wr_addr);

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> ($stable(cal_en) && $stable(tx_amp) && $stable(disc_th)));

  // R5
  cal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && int'(wr_addr) == CAL_ADDR) |=> (cal_en == $past(wr_bit)));

  // R6
  amp_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && int'(wr_addr) == AMP_BASE) |=> (tx_amp[0] == $past(wr_bit)));

  // R7
  disc_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && int'(wr_addr) == DISC_BASE + 1) |=> (disc_th[1] == $past(wr_bit)));

  // R9
  off_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !hit_tune) |=> ($stable(cal_en) && $stable(tx_amp) && $stable(disc_th)));
endmodule

bind cfg_bit_rx cfg_bit_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .wr_addr(wr_addr),
  .wr_bit(wr_bit), .cal_en(cal_en), .tx_amp(tx_amp), .disc_th(disc_th)
);

// File: tb/test_cfg_bit_rx.sv
module test_cfg_bit_rx;
  localparam int       PIDX = 1;
  localparam int       STB  = 2 * PIDX;
  localparam logic [4:0] ARST = 5'h0B;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ctl = '0;
  logic        cal_en;
  logic [4:0]  tx_amp;
  logic [1:0]  disc_th;
  int          errs = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cfg_bit_rx #(.CTL_W(32), .PORT_IDX(PIDX), .AMP_RST(ARST)) i_cfg_bit_rx (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl),
    .cal_en(cal_en), .tx_amp(tx_amp), .disc_th(disc_th)
  );

  // behavioural reference: delay line of sampled words plus a bit array
  logic [31:0] hist[$];
  bit          mem[256];
  bit          last_stb;

  function automatic int m_amp();
    int v = 0;
    for (int k = 0; k < 5; k++) v += int'(mem[32+k]) << k;
    return v;
  endfunction

  function automatic int m_disc();
    return int'(mem[42]) + 2 * int'(mem[43]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {32'h0, 32'h0};
      foreach (mem[i]) mem[i] = 0;
      for (int k = 0; k < 5; k++) mem[32+k] = ARST[k];
      last_stb = 0;
    end else begin
      logic [31:0] w;
      w = hist.pop_front();
      if (w[STB] && !last_stb) mem[w[15:8]] = w[7];
      last_stb = w[STB];
      hist.push_back(ctl);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R8: cycle-by-cycle comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk(cal_en == mem[12],              "R8 cal_en", cal_en,  mem[12]);
    chk(int'(tx_amp) == m_amp(),        "R8 tx_amp", tx_amp,  m_amp());
    chk(int'(disc_th) == m_disc(),      "R8 disc_th", disc_th, m_disc());
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input int a, input bit b, input int sb);
    @(negedge clk);
    ctl = '0; ctl[15:8] = a[7:0]; ctl[7] = b;
    cyc(2); ctl[sb] = 1'b1;
    cyc(4); ctl[sb] = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    // R1
    chk(cal_en == 0,     "R1 cal_en",  cal_en,  0);
    chk(tx_amp == ARST,  "R1 tx_amp",  tx_amp,  ARST);
    chk(disc_th == 0,    "R1 disc_th", disc_th, 0);

    // R2 R5
    put_bit(12, 1, STB);
    chk(cal_en == 1, "R2 R5 cal set", cal_en, 1);

    // R6: amplitude 0x14 bit by bit, LSB at 0x20
    for (int k = 0; k < 5; k++) put_bit(32 + k, (5'h14 >> k) & 1, STB);
    chk(tx_amp == 5'h14, "R6 amp", tx_amp, 5'h14);
    put_bit(32, 1, STB);
    chk(tx_amp == 5'h15, "R6 amp lsb", tx_amp, 5'h15);

    // R7
    put_bit(42, 0, STB); put_bit(43, 1, STB);
    chk(disc_th == 2, "R7 disc 2", disc_th, 2);
    put_bit(42, 1, STB); put_bit(43, 0, STB);
    chk(disc_th == 1, "R7 disc 1", disc_th, 1);

    // R9: off-field addresses
    put_bit(8'h30, 1, STB); put_bit(8'hff, 1, STB); put_bit(8'h0d, 1, STB);
    chk(cal_en == 1 && tx_amp == 5'h15 && disc_th == 1, "R9 outputs",
        {cal_en, tx_amp, disc_th}, {1'b1, 5'h15, 2'd1});

    // R3: other ports' strobes
    put_bit(12, 0, 0); put_bit(12, 0, 4); put_bit(12, 0, 6);
    chk(cal_en == 1, "R3 foreign strobe", cal_en, 1);

    // R4: fields move while strobe low, then while held high
    @(negedge clk); ctl = '0; ctl[15:8] = 8'd42; ctl[7] = 0; cyc(3);
    ctl[15:8] = 8'd12; ctl[7] = 0; cyc(3);
    chk(cal_en == 1 && disc_th == 1, "R4 low change", {cal_en, disc_th}, 3'b101);
    ctl[15:8] = 8'd33; ctl[7] = 1; cyc(2);
    ctl[STB] = 1; cyc(4);
    ctl[15:8] = 8'd42; ctl[7] = 0; cyc(4);
    chk(disc_th == 1, "R4 high change", disc_th, 1);
    chk(tx_amp == 5'h17, "R4 edge write", tx_amp, 5'h17);
    ctl[STB] = 0; cyc(3);

    // R8: exact latency of a capture
    ctl[15:8] = 8'd43; ctl[7] = 1; cyc(2);
    ctl[STB] = 1;
    cyc(2);
    chk(disc_th == 1, "R8 before third edge", disc_th, 1);
    cyc(1);
    chk(disc_th == 3, "R8 at third edge", disc_th, 3);
    ctl[STB] = 0; cyc(3);

    // R10
    put_bit(12, 0, STB);
    chk(cal_en == 0, "R10 clear", cal_en, 0);

    // R1 again after a second reset
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    chk(cal_en == 0 && tx_amp == ARST && disc_th == 0, "R1 re-reset",
        {cal_en, tx_amp, disc_th}, {1'b0, ARST, 2'd0});

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule